// File: doc/BRIEF.md
# FPU Operand Pointer Latch

This block keeps the pointer to the memory operand of the most recent floating-point instruction that used memory. When such an instruction completes, the core pulses a capture strobe and presents three things: a 3-bit index naming the segment register used by the operand, the operand's effective address, and the current processor mode. The block picks the selector of that segment from the six selector values the core supplies. It then stores a 16-bit segment field and a 64-bit pointer field.

The stored form depends on the processor mode. In real and virtual-8086 modes the selector is turned into a linear address and the segment field reads zero. In protected mode the selector and a 32-bit offset are kept apart. In 64-bit mode the whole address goes into the pointer field and the segment field is left as it was. Between strobes both fields hold their values, so save logic elsewhere can read them at any time.

Top module: `opl_top`

## Requirements
- R1: A cycle with `rst` high clears `dseg_q` and `dptr_q` to zero at the next rising edge.
- R2: When `cap_en` is low and `rst` is low, `dseg_q` and `dptr_q` keep their values, whatever the other inputs do.
- R3: Index codes pick a selector slot as follows: 0 picks ES, 1 picks CS, 2 picks SS, 3 picks DS, 4 picks FS and 5 picks GS. Slot i is `seg_sel[16*i+15:16*i]`.
- R4: Index codes 6 and 7 use the DS selector (slot 3).
- R5: With mode code 0 (real) or 1 (virtual-8086), a capture writes zero to `dseg_q`. It writes to `dptr_q` the 32-bit sum `eff_addr[31:0] + selector*16`, zero-extended to 64 bits.
- R6: With mode code 2 (protected), a capture writes the selector to `dseg_q` and `{32'b0, eff_addr[31:0]}` to `dptr_q`.
- R7: With mode code 3 (64-bit), a capture writes all 64 bits of `eff_addr` to `dptr_q` and leaves `dseg_q` unchanged.
- R8: A capture takes effect at the rising edge where `cap_en` is sampled high. Before that edge the outputs show the old values, and after it they show the new ones.
- R9: When `rst` and `cap_en` are high in the same cycle, reset wins and both fields become zero.
- R10: In real and virtual-8086 modes the sum is taken modulo 2^32. A carry out of bit 31 is dropped, and the upper 32 bits of `dptr_q` stay zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cap_en | input | 1 | Capture strobe from a completing memory-operand instruction |
| seg_idx | input | 3 | Effective segment index |
| cpu_mode | input | 2 | 0 real, 1 virtual-8086, 2 protected, 3 64-bit |
| seg_sel | input | 96 | Six 16-bit selectors, slot i at bits 16*i+15 down to 16*i |
| eff_addr | input | 64 | Effective address of the operand |
| dseg_q | output | 16 | Stored data segment field |
| dptr_q | output | 64 | Stored data pointer field |

## Verification
Two functions can fall in the same cycle: reset, and a capture strobe with a valid operand. The bench raises `rst` and `cap_en` together while it presents an operand that would otherwise write non-zero values to both fields. It then requires zeros on both outputs. A second overlap comes from the mode rules. A 64-bit capture writes the pointer in the same cycle in which the segment field must stay put. This is judged by running every mode after a protected capture that has left a known non-zero selector behind.

// File: rtl/opl_pkg.sv
package opl_pkg;

    localparam int SEL_W   = 16;
    localparam int PTR_W   = 64;
    localparam int LIN_W   = 32;
    localparam int PAR_SHF = 4;
    localparam int NUM_SEG = 6;
    localparam int IDX_W   = 3;

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_V86  = 2'd1,
        MODE_PROT = 2'd2,
        MODE_LONG = 2'd3
    } cpu_mode_e;

    typedef enum logic [IDX_W-1:0] {
        SEG_ES = 3'd0,
        SEG_CS = 3'd1,
        SEG_SS = 3'd2,
        SEG_DS = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_idx_e;

    typedef struct packed {
        logic             upd_seg;
        logic [SEL_W-1:0] seg;
        logic [PTR_W-1:0] ptr;
    } cap_rec_t;

    function automatic logic [PTR_W-1:0] real_linear(
        input logic [SEL_W-1:0] sel,
        input logic [PTR_W-1:0] off
    );
        logic [LIN_W-1:0] base;
        logic [LIN_W-1:0] sum;
        base = LIN_W'(sel) << PAR_SHF;
        sum  = off[LIN_W-1:0] + base;
        return PTR_W'(sum);
    endfunction

    function automatic logic [PTR_W-1:0] narrow_offset(input logic [PTR_W-1:0] off);
        return PTR_W'(off[LIN_W-1:0]);
    endfunction

endpackage

// File: rtl/opl_seg_mux.sv
module opl_seg_mux #(
    parameter int NSEG     = opl_pkg::NUM_SEG,
    parameter int SW       = opl_pkg::SEL_W,
    parameter int IW       = opl_pkg::IDX_W,
    parameter int FALLBACK = 3
) (
    input  logic [NSEG*SW-1:0] sel_bus,
    input  logic [IW-1:0]      idx,
    output logic [SW-1:0]      sel_out
);
    logic [SW-1:0] slot [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_slot
        assign slot[g] = sel_bus[g*SW +: SW];
    end

    always_comb begin
        sel_out = slot[FALLBACK];
        for (int i = 0; i < NSEG; i++) begin
            if (idx == IW'(i)) sel_out = slot[i];
        end
    end
endmodule

// File: rtl/opl_form.sv
module opl_form
    import opl_pkg::*;
(
    input  logic [1:0]       mode,
    input  logic [SEL_W-1:0] sel,
    input  logic [PTR_W-1:0] addr,
    output cap_rec_t         rec
);
    cpu_mode_e m;
    assign m = cpu_mode_e'(mode);

    always_comb begin
        rec = '0;
        unique case (m)
            MODE_REAL, MODE_V86: begin
                rec.upd_seg = 1'b1;
                rec.seg     = '0;
                rec.ptr     = real_linear(sel, addr);
            end
            MODE_PROT: begin
                rec.upd_seg = 1'b1;
                rec.seg     = sel;
                rec.ptr     = narrow_offset(addr);
            end
            MODE_LONG: begin
                rec.upd_seg = 1'b0;
                rec.seg     = '0;
                rec.ptr     = addr;
            end
            default: rec = '0;
        endcase
    end
endmodule

// File: rtl/opl_store.sv
module opl_store
    import opl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  cap_rec_t         rec,
    output logic [SEL_W-1:0] seg_q,
    output logic [PTR_W-1:0] ptr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= '0;
            ptr_q <= '0;
        end else if (we) begin
            if (rec.upd_seg) seg_q <= rec.seg;
            ptr_q <= rec.ptr;
        end
    end
endmodule

// File: rtl/opl_top.sv
module opl_top
    import opl_pkg::*;
#(
    parameter int NSEG = NUM_SEG,
    parameter int SW   = SEL_W,
    parameter int PW   = PTR_W,
    parameter int IW   = IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_en,
    input  logic [IW-1:0]      seg_idx,
    input  logic [1:0]         cpu_mode,
    input  logic [NSEG*SW-1:0] seg_sel,
    input  logic [PW-1:0]      eff_addr,
    output logic [SW-1:0]      dseg_q,
    output logic [PW-1:0]      dptr_q
);
    localparam int DS_SLOT = int'(SEG_DS);
    localparam int HI_W    = PW - LIN_W;

    logic [SW-1:0] chosen_sel;
    cap_rec_t      rec;

    opl_seg_mux #(.NSEG(NSEG), .SW(SW), .IW(IW), .FALLBACK(DS_SLOT)) i_mux (
        .sel_bus (seg_sel),
        .idx     (seg_idx),
        .sel_out (chosen_sel)
    );

    opl_form i_form (
        .mode (cpu_mode),
        .sel  (chosen_sel),
        .addr (eff_addr),
        .rec  (rec)
    );

    opl_store i_store (
        .clk   (clk),
        .rst   (rst),
        .we    (cap_en),
        .rec   (rec),
        .seg_q (dseg_q),
        .ptr_q (dptr_q)
    );

    // Assertions
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    always_ff @(posedge clk) begin
        if (rst_d === 1'b1) begin
            AST_RESET_CLEAR: assert (dseg_q == '0 && dptr_q == '0); // R1
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(dseg_q) && $stable(dptr_q)); // R2

    AST_FALLBACK_DS: assert property (@(posedge clk) disable iff (rst)
        (seg_idx >= IW'(NSEG)) |-> chosen_sel == seg_sel[DS_SLOT*SW +: SW]); // R4

    AST_REAL_SEG_ZERO: assert property (@(posedge clk) disable iff (rst)
        cap_en && !cpu_mode[1] |=> dseg_q == '0); // R5

    AST_PROT_SEG_LOAD: assert property (@(posedge clk) disable iff (rst)
        cap_en && cpu_mode == 2'd2 |=> dseg_q == $past(chosen_sel)); // R6

    AST_LONG_SEG_KEEP: assert property (@(posedge clk) disable iff (rst)
        cap_en && cpu_mode == 2'd3 |=> $stable(dseg_q)); // R7

    AST_LONG_PTR_FULL: assert property (@(posedge clk) disable iff (rst)
        cap_en && cpu_mode == 2'd3 |=> dptr_q == $past(eff_addr)); // R7

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        cap_en && cpu_mode != 2'd3 |=> dptr_q[PW-1 -: HI_W] == '0); // R10
endmodule

// File: tb/test_opl_top.sv
module test_opl_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cap_en;
    logic [2:0]  seg_idx;
    logic [1:0]  cpu_mode;
    logic [95:0] seg_sel;
    logic [63:0] eff_addr;
    logic [15:0] dseg_q;
    logic [63:0] dptr_q;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    logic [15:0] exp_seg;
    logic [63:0] exp_ptr;

    always #2 clk = ~clk;

    opl_top i_opl_top (
        .clk(clk), .rst(rst), .cap_en(cap_en), .seg_idx(seg_idx),
        .cpu_mode(cpu_mode), .seg_sel(seg_sel), .eff_addr(eff_addr),
        .dseg_q(dseg_q), .dptr_q(dptr_q)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual cycles %0d expected < 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [15:0] pick(input logic [2:0] idx, input logic [95:0] bus);
        int slot;
        slot = (idx > 3'd5) ? 3 : int'(idx);
        return bus[slot*16 +: 16];
    endfunction

    task automatic check(input string tag);
        checks++;
        if (dseg_q !== exp_seg || dptr_q !== exp_ptr) begin
            fails++;
            $display("FAIL %s: actual seg=%h ptr=%h expected seg=%h ptr=%h",
                     tag, dseg_q, dptr_q, exp_seg, exp_ptr);
        end
    endtask

    task automatic model(input logic [2:0] idx, input logic [1:0] md,
                         input logic [95:0] bus, input logic [63:0] a);
        logic [15:0] s;
        logic [31:0] lin;
        s = pick(idx, bus);
        if (md[1] == 1'b0) begin
            lin = a[31:0] + {12'd0, s, 4'd0};
            exp_seg = 16'h0;
            exp_ptr = {32'd0, lin};
        end else if (md == 2'd2) begin
            exp_seg = s;
            exp_ptr = {32'd0, a[31:0]};
        end else begin
            exp_ptr = a;
        end
    endtask

    task automatic capture(input logic [2:0] idx, input logic [1:0] md,
                           input logic [95:0] bus, input logic [63:0] a);
        @(negedge clk);
        seg_idx = idx; cpu_mode = md; seg_sel = bus; eff_addr = a; cap_en = 1'b1;
        model(idx, md, bus, a);
        @(negedge clk);
        cap_en = 1'b0;
    endtask

    initial begin
        rst = 1'b1; cap_en = 1'b0; seg_idx = '0; cpu_mode = '0;
        seg_sel = '0; eff_addr = '0;
        exp_seg = '0; exp_ptr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset state");

        // Full sweep: patterns x index x mode
        for (int k = 0; k < 6; k++) begin
            for (int ix = 0; ix < 8; ix++) begin
                for (int md = 0; md < 4; md++) begin
                    logic [95:0] bus;
                    logic [63:0] a;
                    for (int s = 0; s < 6; s++)
                        bus[s*16 +: 16] = 16'(16'hF000 + k*16'h03B1 + s*16'h1F07 + md);
                    a = 64'hFEDC_BA98_0000_0000 ^ 64'(k*32'h1357_9BDF + ix*32'h0101_0ACE + md*7);
                    // prime a known non-zero segment field before each long capture
                    if (md == 3) capture(3'(ix), 2'd2, bus, a ^ 64'h55);
                    capture(3'(ix), 2'(md), bus, a);
                    if (ix > 5)         check("R4 fallback to DS");
                    else if (md < 2)    check("R5 real/v86 fold");
                    else if (md == 2)   check("R3,R6 select and protected");
                    else                check("R7 long keeps seg");
                end
            end
        end

        // R2: idle cycles with changing inputs
        capture(3'd4, 2'd2, {6{16'hA5C3}}, 64'h1234_5678_9ABC_DEF0);
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            seg_idx = 3'(j); cpu_mode = 2'(j); seg_sel = {6{16'(j*999)}};
            eff_addr = 64'(j) * 64'h0F0F_0F0F_0F0F_0F0F;
            check("R2 hold without strobe");
        end

        // R10: wrap past 32 bits
        capture(3'd0, 2'd0, {6{16'hFFFF}}, 64'hABCD_0000_FFFF_FFF0);
        checks++;
        if (dptr_q !== 64'h0000_0000_000F_FFE0) begin
            fails++;
            $display("FAIL R10: actual ptr=%h expected ptr=%h", dptr_q, 64'h0000_0000_000F_FFE0);
        end
        check("R10 model agreement");

        // R8: latency - old value just before edge, new after
        @(negedge clk);
        seg_idx = 3'd5; cpu_mode = 2'd2; seg_sel = {16'h7777, 80'd0}; eff_addr = 64'h0000_0000_0000_4444;
        cap_en = 1'b1;
        #1 check("R8 before capture edge");
        model(3'd5, 2'd2, {16'h7777, 80'd0}, 64'h4444);
        @(negedge clk);
        cap_en = 1'b0;
        check("R8 after capture edge");

        // R9: reset and strobe in same cycle
        @(negedge clk);
        rst = 1'b1; cap_en = 1'b1; seg_idx = 3'd2; cpu_mode = 2'd2;
        seg_sel = {6{16'hBEEF}}; eff_addr = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        rst = 1'b0; cap_en = 1'b0;
        exp_seg = '0; exp_ptr = '0;
        check("R9 reset beats strobe");
        check("R1 cleared after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule